// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts the direction of conditional branches. It holds two predictors. The first is a two-level local predictor: a per-branch history table, selected by low fetch-address bits, whose entry picks a 3-bit saturating counter. The second is a global predictor: a 12-bit history of recent resolved outcomes that picks a 2-bit saturating counter. A table of 2-bit chooser counters, also indexed by the global history, decides for each branch which of the two predictions to use. The local side follows a branch's own repeating pattern. The global side follows correlation with the branches that ran just before it.

On the predict side the caller drives the word-address bits of the fetch PC. The block answers in the same cycle. It returns the final direction, both component predictions, the chooser's pick, and every table index it read. When the branch resolves, the caller sends those indices, the two component predictions and the real outcome back on the update side. On the next clock edge all tables are trained and the global history advances. Only one prediction and one update are handled per cycle.

Top module: `tp_tournament`

## Requirements
- R1: After reset every local history entry and the global history read as zero. Every local counter holds 3 (binary 011) and every global counter holds 1 (binary 01), so both component predictions are not-taken. Every chooser counter holds 1 (binary 01), so the local prediction is selected.
- R2: `pred_lht_idx` equals `pred_pc_lo`. `pred_lhist` is the local history entry stored at that index. `pred_ghist` is the current global history. All three are combinational from the current state.
- R3: The local counter read is the one indexed by `pred_lhist`. `pred_local` is its most significant bit. An update moves the counter at `upd_lhist` up by one on a taken outcome and down by one otherwise.
- R4: The global counter read is the one indexed by `pred_ghist`. `pred_global` is its most significant bit. An update moves the counter at `upd_ghist` up by one on taken and down by one otherwise.
- R5: `pred_sel_global` is the most significant bit of the chooser counter at `pred_ghist`. `pred_taken` equals `pred_global` when it is 1 and `pred_local` when it is 0. The chooser counter at `upd_ghist` changes only when `upd_local_pred` differs from `upd_global_pred`. It then moves up by one if the global prediction matched the outcome and down by one if the local prediction did.
- R6: Each update shifts the outcome into bit 0 of the global history and drops the oldest bit. Without an update the history holds its value.
- R7: Each update replaces the local history entry at `upd_lht_idx` with that entry shifted left by one, with the outcome in bit 0.
- R8: When a prediction and an update fall in the same cycle, the prediction outputs show the state from before the update. The trained state becomes visible one cycle later.
- R9: Every counter (local 0..7, global 0..3, chooser 0..3) saturates: a step past either end leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc_lo | input | 10 | Word-address bits of the fetch PC used to index the local history table |
| pred_taken | output | 1 | Final predicted direction (1 = taken) |
| pred_lht_idx | output | 10 | Local history table index used |
| pred_lhist | output | 10 | Local history read; index of the local counter used |
| pred_ghist | output | 12 | Global history; index of the global and chooser counters used |
| pred_local | output | 1 | Local component prediction |
| pred_global | output | 1 | Global component prediction |
| pred_sel_global | output | 1 | Chooser pick (1 = global) |
| upd_valid | input | 1 | Update strobe for a resolved branch |
| upd_lht_idx | input | 10 | Local history entry to shift |
| upd_lhist | input | 10 | Local counter to train |
| upd_ghist | input | 12 | Global and chooser counters to train |
| upd_local_pred | input | 1 | Local prediction made for this branch |
| upd_global_pred | input | 1 | Global prediction made for this branch |
| upd_taken | input | 1 | Resolved outcome (1 = taken) |

## Verification
A lookup and a training write can land in the same cycle and even touch the same entries. The bench points the predict port at the local history entry that the concurrent update shifts, with both using counter 0 and global history 0. It checks the outputs before the clock edge against the untrained values. After the edge it checks the shifted histories and the stepped counter, reading the counter through a second address whose history is still zero.

// File: rtl/tp_pkg.sv
package tp_pkg;

  // Saturating one-step move of a counter of width w (w <= 8).
  function automatic logic [7:0] sat_step(logic [7:0] val, logic up, int unsigned w);
    logic [7:0] top;
    top = (8'd1 << w) - 8'd1;
    if (up)
      sat_step = (val == top) ? val : val + 8'd1;
    else
      sat_step = (val == 8'd0) ? val : val - 8'd1;
  endfunction

  // Weak not-taken start value for a counter of width w.
  function automatic logic [7:0] weak_low(int unsigned w);
    weak_low = (8'd1 << (w - 1)) - 8'd1;
  endfunction

endpackage

// File: rtl/tp_local_pred.sv
module tp_local_pred #(
  parameter int LHT_DEPTH = 1024,
  parameter int LHIST_W   = 10,
  parameter int LCTR_W    = 3,
  parameter int IDX_W     = $clog2(LHT_DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [LHIST_W-1:0] rd_hist,
  output logic               rd_taken,
  input  logic               upd_valid,
  input  logic [IDX_W-1:0]   upd_idx,
  input  logic [LHIST_W-1:0] upd_hist,
  input  logic               upd_taken
);
  localparam int LCTR_DEPTH = 1 << LHIST_W;
  localparam logic [7:0] LCTR_INIT8 = tp_pkg::weak_low(LCTR_W);
  localparam logic [LCTR_W-1:0] LCTR_INIT = LCTR_INIT8[LCTR_W-1:0];
  localparam logic [LCTR_W-1:0] LCTR_MAX = '1;

  logic [LHIST_W-1:0] lht_q  [LHT_DEPTH];
  logic [LCTR_W-1:0]  lctr_q [LCTR_DEPTH];

  // named internal events
  wire [7:0]         lctr_cur  = 8'(lctr_q[upd_hist]);
  wire [7:0]         lctr_nxt8 = tp_pkg::sat_step(lctr_cur, upd_taken, LCTR_W);
  wire [LHIST_W-1:0] lht_nxt   = {lht_q[upd_idx][LHIST_W-2:0], upd_taken};

  assign rd_hist  = lht_q[rd_idx];
  assign rd_taken = lctr_q[rd_hist][LCTR_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LHT_DEPTH; i++) lht_q[i] <= '0;
      for (int j = 0; j < LCTR_DEPTH; j++) lctr_q[j] <= LCTR_INIT;
    end else if (upd_valid) begin
      lht_q[upd_idx]   <= lht_nxt;
      lctr_q[upd_hist] <= lctr_nxt8[LCTR_W-1:0];
    end
  end

  // R7: newest outcome lands in bit 0 of the trained history entry
  p_lht_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> lht_q[$past(upd_idx)][0] == $past(upd_taken));

  // R9: a saturated local counter stays saturated on a further taken outcome
  p_lctr_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && (lctr_q[upd_hist] == LCTR_MAX))
      |=> lctr_q[$past(upd_hist)] == LCTR_MAX);

endmodule

// File: rtl/tp_global_pred.sv
module tp_global_pred #(
  parameter int GHIST_W = 12,
  parameter int GCTR_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [GHIST_W-1:0] ghist,
  output logic               rd_taken,
  input  logic               upd_valid,
  input  logic [GHIST_W-1:0] upd_ghist,
  input  logic               upd_taken
);
  localparam int GCTR_DEPTH = 1 << GHIST_W;
  localparam logic [7:0] GCTR_INIT8 = tp_pkg::weak_low(GCTR_W);
  localparam logic [GCTR_W-1:0] GCTR_INIT = GCTR_INIT8[GCTR_W-1:0];

  logic [GHIST_W-1:0] ghr_q;
  logic [GCTR_W-1:0]  gctr_q [GCTR_DEPTH];

  wire [7:0]         gctr_cur  = 8'(gctr_q[upd_ghist]);
  wire [7:0]         gctr_nxt8 = tp_pkg::sat_step(gctr_cur, upd_taken, GCTR_W);
  wire [GHIST_W-1:0] ghr_nxt   = {ghr_q[GHIST_W-2:0], upd_taken};

  assign ghist    = ghr_q;
  assign rd_taken = gctr_q[ghr_q][GCTR_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ghr_q <= '0;
      for (int i = 0; i < GCTR_DEPTH; i++) gctr_q[i] <= GCTR_INIT;
    end else if (upd_valid) begin
      ghr_q             <= ghr_nxt;
      gctr_q[upd_ghist] <= gctr_nxt8[GCTR_W-1:0];
    end
  end

  // R6: the resolved outcome enters the history at bit 0
  p_ghr_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> ghr_q[0] == $past(upd_taken));

  // R6: the history is frozen when nothing resolves
  p_ghr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(ghr_q));

endmodule

// File: rtl/tp_chooser.sv
module tp_chooser #(
  parameter int GHIST_W = 12,
  parameter int CCTR_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [GHIST_W-1:0] rd_idx,
  output logic               sel_global,
  input  logic               upd_valid,
  input  logic [GHIST_W-1:0] upd_idx,
  input  logic               upd_local_pred,
  input  logic               upd_global_pred,
  input  logic               upd_taken
);
  localparam int CCTR_DEPTH = 1 << GHIST_W;
  localparam logic [7:0] CCTR_INIT8 = tp_pkg::weak_low(CCTR_W);
  localparam logic [CCTR_W-1:0] CCTR_INIT = CCTR_INIT8[CCTR_W-1:0];

  logic [CCTR_W-1:0] cctr_q [CCTR_DEPTH];

  // named internal events
  wire       choice_train = upd_valid && (upd_local_pred != upd_global_pred);
  wire       choice_up    = (upd_global_pred == upd_taken);
  wire [7:0] cctr_cur     = 8'(cctr_q[upd_idx]);
  wire [7:0] cctr_nxt8    = tp_pkg::sat_step(cctr_cur, choice_up, CCTR_W);

  assign sel_global = cctr_q[rd_idx][CCTR_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < CCTR_DEPTH; i++) cctr_q[i] <= CCTR_INIT;
    end else if (choice_train) begin
      cctr_q[upd_idx] <= cctr_nxt8[CCTR_W-1:0];
    end
  end

  // R5: agreement between components leaves the chooser entry untouched
  p_choice_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && (upd_local_pred == upd_global_pred))
      |=> cctr_q[$past(upd_idx)] == $past(cctr_q[upd_idx]));

endmodule

// File: rtl/tp_tournament.sv
module tp_tournament #(
  parameter int LHT_DEPTH = 1024,
  parameter int LHIST_W   = 10,
  parameter int LCTR_W    = 3,
  parameter int GHIST_W   = 12,
  parameter int GCTR_W    = 2,
  parameter int CCTR_W    = 2,
  parameter int LIDX_W    = $clog2(LHT_DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LIDX_W-1:0]  pred_pc_lo,
  output logic               pred_taken,
  output logic [LIDX_W-1:0]  pred_lht_idx,
  output logic [LHIST_W-1:0] pred_lhist,
  output logic [GHIST_W-1:0] pred_ghist,
  output logic               pred_local,
  output logic               pred_global,
  output logic               pred_sel_global,
  input  logic               upd_valid,
  input  logic [LIDX_W-1:0]  upd_lht_idx,
  input  logic [LHIST_W-1:0] upd_lhist,
  input  logic [GHIST_W-1:0] upd_ghist,
  input  logic               upd_local_pred,
  input  logic               upd_global_pred,
  input  logic               upd_taken
);

  assign pred_lht_idx = pred_pc_lo;

  tp_local_pred #(
    .LHT_DEPTH(LHT_DEPTH), .LHIST_W(LHIST_W), .LCTR_W(LCTR_W), .IDX_W(LIDX_W)
  ) u_local (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (pred_pc_lo),
    .rd_hist   (pred_lhist),
    .rd_taken  (pred_local),
    .upd_valid (upd_valid),
    .upd_idx   (upd_lht_idx),
    .upd_hist  (upd_lhist),
    .upd_taken (upd_taken)
  );

  tp_global_pred #(
    .GHIST_W(GHIST_W), .GCTR_W(GCTR_W)
  ) u_global (
    .clk       (clk),
    .rst_n     (rst_n),
    .ghist     (pred_ghist),
    .rd_taken  (pred_global),
    .upd_valid (upd_valid),
    .upd_ghist (upd_ghist),
    .upd_taken (upd_taken)
  );

  tp_chooser #(
    .GHIST_W(GHIST_W), .CCTR_W(CCTR_W)
  ) u_chooser (
    .clk             (clk),
    .rst_n           (rst_n),
    .rd_idx          (pred_ghist),
    .sel_global      (pred_sel_global),
    .upd_valid       (upd_valid),
    .upd_idx         (upd_ghist),
    .upd_local_pred  (upd_local_pred),
    .upd_global_pred (upd_global_pred),
    .upd_taken       (upd_taken)
  );

  assign pred_taken = pred_sel_global ? pred_global : pred_local;

  // R5: when both components agree the final direction is theirs
  p_agree_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_local == pred_global) |-> (pred_taken == pred_local));

  // R5: the final direction always comes from one of the components
  p_from_component_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_taken == pred_local) || (pred_taken == pred_global));

endmodule

// File: tb/test_tp_tournament.sv
module test_tp_tournament;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  pred_pc_lo = '0;
  logic        pred_taken;
  logic [9:0]  pred_lht_idx;
  logic [9:0]  pred_lhist;
  logic [11:0] pred_ghist;
  logic        pred_local, pred_global, pred_sel_global;
  logic        upd_valid = 1'b0;
  logic [9:0]  upd_lht_idx = '0;
  logic [9:0]  upd_lhist = '0;
  logic [11:0] upd_ghist = '0;
  logic        upd_local_pred = 1'b0, upd_global_pred = 1'b0, upd_taken = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tp_tournament i_tp_tournament (
    .clk(clk), .rst_n(rst_n), .pred_pc_lo(pred_pc_lo),
    .pred_taken(pred_taken), .pred_lht_idx(pred_lht_idx), .pred_lhist(pred_lhist),
    .pred_ghist(pred_ghist), .pred_local(pred_local), .pred_global(pred_global),
    .pred_sel_global(pred_sel_global), .upd_valid(upd_valid),
    .upd_lht_idx(upd_lht_idx), .upd_lhist(upd_lhist), .upd_ghist(upd_ghist),
    .upd_local_pred(upd_local_pred), .upd_global_pred(upd_global_pred),
    .upd_taken(upd_taken)
  );

  function automatic int step(int v, bit up, int maxv);
    if (up) return (v >= maxv) ? maxv : v + 1;
    return (v <= 0) ? 0 : v - 1;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    upd_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic probe(logic [9:0] pc);
    pred_pc_lo = pc;
    #1;
  endtask

  // called just after a negedge; returns just after the following negedge
  task automatic upd(logic [9:0] li, logic [9:0] lh, logic [11:0] gh,
                     bit lp, bit gp, bit tk);
    upd_lht_idx = li; upd_lhist = lh; upd_ghist = gh;
    upd_local_pred = lp; upd_global_pred = gp; upd_taken = tk;
    upd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    upd_valid = 1'b0;
    #1;
  endtask

  task automatic flush_ghr();
    for (int k = 0; k < 12; k++) upd(10'h3FF, 10'h3FF, 12'h555, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    do_reset();
    probe(10'h2A5);
    check("R1 taken", pred_taken, 0);
    check("R1 local", pred_local, 0);
    check("R1 global", pred_global, 0);
    check("R1 sel", pred_sel_global, 0);
    check("R1 lhist", pred_lhist, 0);
    check("R1 ghist", pred_ghist, 0);
    check("R2 lht_idx", pred_lht_idx, 'h2A5);
  endtask

  task automatic t_ghr();
    bit pat [4] = '{1'b1, 1'b0, 1'b1, 1'b1};
    int model = 0;
    do_reset();
    foreach (pat[k]) begin
      upd(10'h3FF, 10'h3FF, 12'h800, 1'b0, 1'b0, pat[k]);
      model = ((model << 1) | pat[k]) & 'hFFF;
      check("R6 ghist shift", pred_ghist, model);
    end
    @(negedge clk); #1;
    check("R6 ghist hold", pred_ghist, 'hB);
  endtask

  task automatic t_lht();
    do_reset();
    upd(10'h123, 10'h3FF, 12'h7FF, 1'b0, 1'b0, 1'b1);
    upd(10'h123, 10'h3FF, 12'h7FF, 1'b0, 1'b0, 1'b1);
    upd(10'h123, 10'h3FF, 12'h7FF, 1'b0, 1'b0, 1'b0);
    probe(10'h123);
    check("R7 lhist entry", pred_lhist, 'h6);
    check("R2 lht_idx", pred_lht_idx, 'h123);
    probe(10'h124);
    check("R7 neighbour lhist", pred_lhist, 0);
  endtask

  task automatic t_local_ctr();
    bit seq [9] = '{1,1,1,1,1,0,0,0,0};
    int m = 3;
    do_reset();
    probe(10'h010);
    foreach (seq[k]) begin
      upd(10'h3FF, 10'h000, 12'h555, 1'b0, 1'b0, seq[k]);
      m = step(m, seq[k], 7);
      check("R3 R9 local ctr", pred_local, (m >> 2) & 1);
      check("R5 default local", pred_taken, (m >> 2) & 1);
    end
  endtask

  task automatic t_global_ctr();
    int m = 1;
    do_reset();
    for (int k = 0; k < 12; k++) begin
      upd(10'h3FF, 10'h3FE, 12'hFFF, 1'b0, 1'b0, 1'b1);
      m = step(m, 1'b1, 3);
    end
    check("R4 ghist", pred_ghist, 'hFFF);
    check("R4 R9 global top", pred_global, (m >> 1) & 1);
    do_reset();
    m = 1;
    for (int k = 0; k < 3; k++) begin
      upd(10'h3FF, 10'h3FE, 12'h000, 1'b0, 1'b0, 1'b0);
      m = step(m, 1'b0, 3);
    end
    check("R4 global low", pred_global, (m >> 1) & 1);
    upd(10'h3FF, 10'h3FE, 12'h000, 1'b0, 1'b0, 1'b1);
    m = step(m, 1'b1, 3);
    flush_ghr();
    check("R4 ghist flushed", pred_ghist, 0);
    check("R9 global bottom sat", pred_global, (m >> 1) & 1);
    upd(10'h3FF, 10'h3FE, 12'h000, 1'b0, 1'b0, 1'b1);
    m = step(m, 1'b1, 3);
    flush_ghr();
    check("R4 global rise", pred_global, (m >> 1) & 1);
  endtask

  task automatic t_chooser();
    // local prediction, global prediction, outcome
    bit lps [7] = '{0,1,1,1,1,1,0};
    bit gps [7] = '{1,0,0,1,0,0,1};
    int c = 1;
    do_reset();
    probe(10'h010);
    upd(10'h3FF, 10'h000, 12'h555, 1'b0, 1'b0, 1'b1);
    flush_ghr();
    check("R5 setup ghist", pred_ghist, 0);
    check("R5 setup local", pred_local, 1);
    check("R5 setup global", pred_global, 0);
    check("R5 picks local", pred_taken, 1);
    foreach (lps[k]) begin
      upd(10'h3FF, 10'h3FF, 12'h000, lps[k], gps[k], 1'b0);
      if (lps[k] != gps[k]) c = step(c, gps[k] == 1'b0, 3);
      check("R5 R9 chooser", pred_sel_global, (c >> 1) & 1);
      check("R5 final", pred_taken, ((c >> 1) & 1) ? 0 : 1);
    end
    // one more local-correct step takes the chooser below the midpoint
    upd(10'h3FF, 10'h3FF, 12'h000, 1'b0, 1'b1, 1'b0);
    c = step(c, 1'b0, 3);
    check("R5 chooser back", pred_sel_global, (c >> 1) & 1);
  endtask

  task automatic t_same_cycle();
    do_reset();
    pred_pc_lo = 10'h040;
    upd_lht_idx = 10'h040; upd_lhist = 10'h000; upd_ghist = 12'h000;
    upd_local_pred = 1'b0; upd_global_pred = 1'b0; upd_taken = 1'b1;
    upd_valid = 1'b1;
    #1;
    check("R8 pre lhist", pred_lhist, 0);
    check("R8 pre ghist", pred_ghist, 0);
    check("R8 pre local", pred_local, 0);
    check("R8 pre global", pred_global, 0);
    @(posedge clk);
    @(negedge clk);
    upd_valid = 1'b0;
    #1;
    check("R8 post lhist", pred_lhist, 1);
    check("R8 post ghist", pred_ghist, 1);
    probe(10'h041);
    check("R8 post local ctr", pred_local, 1);
  endtask

  initial begin
    t_reset();
    t_ghr();
    t_lht();
    t_local_ctr();
    t_global_ctr();
    t_chooser();
    t_same_cycle();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule